// File: doc/BRIEF.md
# Reset-Time Oscillator Trim Loader

This block puts the on-chip oscillator on a factory trim value before the processor core is allowed to run. A small read-only signature store holds two trim bytes, one measured for the full-rate clock setting and one for the half-rate setting. Each byte sits in the upper half of its own store word. After reset is released, the loader reads one word through a synchronous read port and keeps the upper byte. It writes that byte into the calibration register and only then lets the core out of reset.

By default the loader always fetches the full-rate trim, at word 0, whatever clock mode is selected. The two trims can be around 32 codes apart, so a part running at half rate comes up noticeably off frequency unless firmware writes the half-rate trim, found at word 1, itself. Setting the `MATCH_MODE` strap makes the loader pick the word that matches the selected mode. Once loading has finished, software may overwrite the calibration register through a write port. Any software write that arrives before then is dropped.

Top module: `osc_trim_loader`

## Requirements
- R1: While `rst` is high, `core_hold` is 1, `load_done` is 0, `mem_rd_en` is 0 and `trim_value` is 0.
- R2: Each load issues exactly one store read. `mem_rd_en` is high for a single cycle, the first cycle after the first rising edge at which `rst` is sampled low.
- R3: With `MATCH_MODE` = 0, the read goes to word address 0 and `trim_value` ends up equal to bits [15:8] of word 0, whatever the value of `half_mode`.
- R4: With `MATCH_MODE` = 1, the read goes to word address 1 when `half_mode` = 1 and to word address 0 when `half_mode` = 0. `trim_value` ends up equal to bits [15:8] of the word that was read.
- R5: Bits [7:0] of the word read have no effect on `trim_value`.
- R6: `load_done` rises and `core_hold` falls on the fourth rising edge at which `rst` is sampled low. The loaded trim appears on `trim_value` at that same edge. After that, `load_done` stays 1 until reset.
- R7: While `load_done` is 0, a software write (`sw_wr_en` = 1) does not change `trim_value`.
- R8: While `load_done` is 1, a software write sets `trim_value` to `sw_wr_data` on the next rising edge and leaves `load_done` and `core_hold` unchanged.
- R9: Asserting `rst` again clears `trim_value` to 0 and a fresh load follows, with the same timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| half_mode | input | 1 | Selected clock mode: 1 = half rate, 0 = full rate |
| mem_rd_en | output | 1 | Read strobe to the signature store |
| mem_addr | output | ADDR_W (4) | Word address to the signature store |
| mem_rdata | input | WORD_W (16) | Store read data, valid one cycle after the strobe |
| sw_wr_en | input | 1 | Software write strobe for the calibration register |
| sw_wr_data | input | TRIM_W (8) | Software write value |
| core_hold | output | 1 | Holds the core in reset while high |
| load_done | output | 1 | Set once the trim has been loaded |
| trim_value | output | TRIM_W (8) | Current calibration register contents |

## Verification
Once `rst` is sampled low, the read strobe is due one edge later. `load_done`, `core_hold` and the loaded trim all change together on the fourth edge, and a software write after release shows on the edge that follows it. The bench drives inputs on falling edges and checks on the falling edge after each rising edge. It compares every cycle of the load window against these edge counts, so an early or late change shows up as a mismatch. A sweep over 16 trim patterns and both clock modes runs two instances side by side, one with the strap off and one with it on. The expected trim and address are computed from the pattern. Software writes stay asserted through the whole load to show that they are ignored.

// File: rtl/trim_pkg.sv
package trim_pkg;
  typedef enum logic [2:0] {
    LS_RESET   = 3'd0,
    LS_ISSUE   = 3'd1,
    LS_CAPTURE = 3'd2,
    LS_WRITE   = 3'd3,
    LS_RELEASE = 3'd4
  } load_state_e;
endpackage

// File: rtl/trim_seq.sv
module trim_seq #(
  parameter int WORD_W     = 16,
  parameter int ADDR_W     = 4,
  parameter int TRIM_W     = 8,
  parameter int MATCH_MODE = 0,
  parameter int FULL_ADDR  = 0,
  parameter int HALF_ADDR  = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              half_mode,
  input  logic [WORD_W-1:0] rdata,
  output logic              rd_en,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              ld_wr,
  output logic [TRIM_W-1:0] ld_data,
  output logic              done
);
  import trim_pkg::*;

  localparam int HI_LSB = WORD_W - TRIM_W;
  localparam logic [ADDR_W-1:0] A_FULL = ADDR_W'(FULL_ADDR);
  localparam logic [ADDR_W-1:0] A_HALF = ADDR_W'(HALF_ADDR);

  load_state_e       state_q;
  logic [TRIM_W-1:0] cap_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= LS_RESET;
      cap_q   <= '0;
    end else begin
      case (state_q)
        LS_RESET:   state_q <= LS_ISSUE;
        LS_ISSUE:   state_q <= LS_CAPTURE;
        LS_CAPTURE: begin
          cap_q   <= TRIM_W'(rdata >> HI_LSB);
          state_q <= LS_WRITE;
        end
        LS_WRITE:   state_q <= LS_RELEASE;
        default:    state_q <= LS_RELEASE;
      endcase
    end
  end

  assign rd_en   = (state_q == LS_ISSUE);
  assign rd_addr = ((MATCH_MODE != 0) && half_mode) ? A_HALF : A_FULL;
  assign ld_wr   = (state_q == LS_WRITE);
  assign ld_data = cap_q;
  assign done    = (state_q == LS_RELEASE);

  // R2: the read strobe lasts a single cycle
  p_single_read_r2: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> !rd_en);

  generate
    if (MATCH_MODE == 0) begin : g_fixed
      // R3: with the strap off, only the full-rate word is read
      p_fixed_addr_r3: assert property (@(posedge clk) disable iff (rst)
        rd_en |-> (rd_addr == A_FULL));
    end else begin : g_match
      // R4: with the strap on, the address follows the mode
      p_match_addr_r4: assert property (@(posedge clk) disable iff (rst)
        rd_en |-> (rd_addr == (half_mode ? A_HALF : A_FULL)));
    end
  endgenerate
endmodule

// File: rtl/trim_reg.sv
module trim_reg #(
  parameter int TRIM_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld_wr,
  input  logic [TRIM_W-1:0] ld_data,
  input  logic              done,
  input  logic              sw_en,
  input  logic [TRIM_W-1:0] sw_data,
  output logic [TRIM_W-1:0] trim_q
);
  always_ff @(posedge clk) begin
    if (rst)                trim_q <= '0;
    else if (ld_wr)         trim_q <= ld_data;
    else if (done && sw_en) trim_q <= sw_data;
  end

  // R7: software writes before release leave the register untouched
  p_ignore_early_sw_r7: assert property (@(posedge clk) disable iff (rst)
    (!done && sw_en && !ld_wr) |=> $stable(trim_q));

  // R8: software writes after release land on the next edge
  p_sw_write_r8: assert property (@(posedge clk) disable iff (rst)
    (done && sw_en) |=> (trim_q == $past(sw_data)));
endmodule

// File: rtl/osc_trim_loader.sv
module osc_trim_loader #(
  parameter int WORD_W     = 16,
  parameter int ADDR_W     = 4,
  parameter int TRIM_W     = 8,
  parameter int MATCH_MODE = 0,
  parameter int FULL_ADDR  = 0,
  parameter int HALF_ADDR  = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              half_mode,
  output logic              mem_rd_en,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [WORD_W-1:0] mem_rdata,
  input  logic              sw_wr_en,
  input  logic [TRIM_W-1:0] sw_wr_data,
  output logic              core_hold,
  output logic              load_done,
  output logic [TRIM_W-1:0] trim_value
);
  logic              ld_wr;
  logic [TRIM_W-1:0] ld_data;
  logic              done;

  trim_seq #(
    .WORD_W(WORD_W), .ADDR_W(ADDR_W), .TRIM_W(TRIM_W),
    .MATCH_MODE(MATCH_MODE), .FULL_ADDR(FULL_ADDR), .HALF_ADDR(HALF_ADDR)
  ) u_seq (
    .clk(clk), .rst(rst), .half_mode(half_mode), .rdata(mem_rdata),
    .rd_en(mem_rd_en), .rd_addr(mem_addr), .ld_wr(ld_wr),
    .ld_data(ld_data), .done(done)
  );

  trim_reg #(.TRIM_W(TRIM_W)) u_reg (
    .clk(clk), .rst(rst), .ld_wr(ld_wr), .ld_data(ld_data), .done(done),
    .sw_en(sw_wr_en), .sw_data(sw_wr_data), .trim_q(trim_value)
  );

  assign load_done = done;
  assign core_hold = ~done;

  // R6: once released, the core stays released until reset
  p_done_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    load_done |=> load_done);

  // R2: release comes exactly three cycles after the read strobe
  p_read_then_done_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(load_done) |-> $past(mem_rd_en, 3));
endmodule

// File: tb/sim_osc_trim_loader.sv
module sim_osc_trim_loader;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic half_mode = 1'b0;
  logic sw_wr_en = 1'b0;
  logic [7:0] sw_wr_data = 8'h00;
  logic [7:0] full_hi = 8'h00, half_hi = 8'h00, lo_fill = 8'h00;

  logic rd0, rd1, hold0, hold1, done0, done1;
  logic [3:0] addr0, addr1;
  logic [15:0] rdata0 = '0, rdata1 = '0;
  logic [7:0] trim0, trim1;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [15:0] mem_word(input logic [3:0] a);
    if (a == 4'd0)      return {full_hi, lo_fill};
    else if (a == 4'd1) return {half_hi, ~lo_fill};
    else                return {8'hEE, lo_fill};
  endfunction

  always_ff @(posedge clk) begin
    if (rd0) rdata0 <= mem_word(addr0);
    if (rd1) rdata1 <= mem_word(addr1);
  end

  osc_trim_loader #(.MATCH_MODE(0)) u0 (
    .clk(clk), .rst(rst), .half_mode(half_mode), .mem_rd_en(rd0),
    .mem_addr(addr0), .mem_rdata(rdata0), .sw_wr_en(sw_wr_en),
    .sw_wr_data(sw_wr_data), .core_hold(hold0), .load_done(done0),
    .trim_value(trim0));

  osc_trim_loader #(.MATCH_MODE(1)) u1 (
    .clk(clk), .rst(rst), .half_mode(half_mode), .mem_rd_en(rd1),
    .mem_addr(addr1), .mem_rdata(rdata1), .sw_wr_en(sw_wr_en),
    .sw_wr_data(sw_wr_data), .core_hold(hold1), .load_done(done1),
    .trim_value(trim1));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic run_load(input int seed, input logic mode);
    logic [7:0] exp1;
    logic [7:0] swv;
    @(negedge clk);
    full_hi = 8'(seed * 37 + 41);
    half_hi = full_hi - 8'd32;
    lo_fill = 8'(seed * 11 + 5);
    rst = 1'b1; half_mode = mode;
    sw_wr_en = 1'b1; sw_wr_data = 8'h5A;
    @(negedge clk);
    @(negedge clk);
    // R1 and R9: reset state, including after an earlier software write
    chk("R1 hold0", hold0, 1); chk("R1 done0", done0, 0);
    chk("R1 rd0", rd0, 0);     chk("R9 trim0 cleared", trim0, 0);
    chk("R1 trim1", trim1, 0);
    rst = 1'b0;
    @(negedge clk); // edge e0: read issued
    chk("R2 rd0 strobe", rd0, 1); chk("R2 rd1 strobe", rd1, 1);
    chk("R3 addr0", addr0, 0);
    chk("R4 addr1", addr1, mode ? 1 : 0);
    chk("R7 trim0 during load", trim0, 0);
    @(negedge clk); // e1
    chk("R2 rd0 single", rd0, 0);
    chk("R6 done0 early", done0, 0);
    chk("R7 trim0 during load", trim0, 0);
    @(negedge clk); // e2
    chk("R6 hold0 early", hold0, 1);
    chk("R7 trim1 during load", trim1, 0);
    @(negedge clk); // e3: release
    exp1 = mode ? half_hi : full_hi;
    chk("R6 done0", done0, 1); chk("R6 hold0", hold0, 0);
    chk("R6 done1", done1, 1);
    chk("R3 R5 trim0", trim0, full_hi);
    chk("R4 R5 trim1", trim1, exp1);
    sw_wr_en = 1'b0;
    @(negedge clk);
    chk("R8 trim0 idle", trim0, full_hi);
    swv = 8'(seed) ^ 8'hC3;
    sw_wr_en = 1'b1; sw_wr_data = swv;
    @(negedge clk);
    sw_wr_en = 1'b0;
    chk("R8 trim0 sw", trim0, swv); chk("R8 trim1 sw", trim1, swv);
    chk("R8 done0 kept", done0, 1); chk("R8 hold0 kept", hold0, 0);
  endtask

  initial begin
    for (int s = 0; s < 16; s++) begin
      for (int m = 0; m < 2; m++) begin
        run_load(s, m[0]);
      end
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule